// File: doc/BRIEF.md
# Platform Control and Status Port Bank

This block sits on a byte-wide I/O port bus and gathers a set of small platform registers behind fixed 16-bit port numbers. A host issues a read or a write strobe along with a port number. Read data returns combinationally in the same cycle. A write takes effect at the next rising clock edge.

Writes can do four things. They can request a one-cycle soft-reset pulse. They can flag two configuration requests that the platform does not support: a little-endian request and a non-contiguous I/O map request. Each of these sets a fault flag that stays set. They can flip either of two NVRAM protection bits. They can load a general system control byte.

Several ports are read-only and return fixed status bytes for hardware this block does not contain. Reads of any other port return all ones.

Top module: `sysreg_bank`

## Requirements
- R1: A synchronous active-high reset clears the lock pair, the control byte, both fault flags and the soft-reset pulse to zero.
- R2: A write to port 0x0092 with data bit 7 set drives `soft_reset` high for exactly the following cycle. A write with bit 7 clear produces no pulse.
- R3: A write to port 0x0092 with data bit 6 set sets `endian_fault` from the following cycle. The flag then stays set until reset.
- R4: A read of port 0x0092 returns 0x40.
- R5: Every write to port 0x0810 inverts `nv_lock[0]`, and every write to port 0x0812 inverts `nv_lock[1]`. The written data plays no part.
- R6: A write to port 0x081C loads the control byte. From the following cycle the new value appears on `sys_ctrl` and is returned by reads of 0x081C.
- R7: Reads of port 0x080C return 0xFC, port 0x0818 return 0x00, port 0x0823 return 0x03, and port 0x0850 return 0x00.
- R8: A write to port 0x0850 with data bit 7 set sets `map_fault` from the following cycle. The flag then stays set until reset. A write to 0x0850 with bit 7 clear leaves the flag unchanged.
- R9: A read of any port not named in R4, R6 or R7 returns 0xFF. This includes the write-only lock ports. While `rd_en` is low, `rd_data` is 0x00.
- R10: Writes to ports 0x0808 and 0x0814, to the read-only ports, and to undecoded ports change none of `nv_lock`, `sys_ctrl`, `endian_fault`, `map_fault` or `soft_reset`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_addr | input | 16 | Port number of the current access |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid in the same cycle as `rd_en` |
| soft_reset | output | 1 | One-cycle soft-reset request |
| endian_fault | output | 1 | Sticky flag for an unsupported little-endian request |
| map_fault | output | 1 | Sticky flag for an unsupported I/O map request |
| nv_lock | output | 2 | NVRAM protection bits |
| sys_ctrl | output | 8 | System control byte |

## Verification
The assertions assume that the host never raises `rd_en` and `wr_en` in the same cycle. They also assume that `port_addr` and `wr_data` are stable across each clock edge at which a strobe is sampled. The stimulus keeps to both assumptions. It issues one access per cycle, each either a read, a write or an idle. It changes every input only on the falling clock edge.

Because the toggle ports and the sticky flags carry history, the sequence includes several points that exercise it. It writes each lock port repeatedly with different data. It sets each fault flag and then issues unrelated writes. It applies a second reset in the middle of the run to show that everything clears.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;

  typedef enum int {
    SEL_SPECIAL = 0,
    SEL_EQUIP   = 1,
    SEL_KEYLOCK = 2,
    SEL_SYSCTL  = 3,
    SEL_CACHEST = 4,
    SEL_MAPTYPE = 5,
    SEL_LOCK_A  = 6,
    SEL_LOCK_B  = 7
  } sel_e;

  localparam int NSEL = 8;

  localparam logic [DATA_W-1:0] RD_SPECIAL = 8'h40;
  localparam logic [DATA_W-1:0] RD_EQUIP   = 8'hFC;
  localparam logic [DATA_W-1:0] RD_KEYLOCK = 8'h00;
  localparam logic [DATA_W-1:0] RD_CACHEST = 8'h03;
  localparam logic [DATA_W-1:0] RD_MAPTYPE = 8'h00;
  localparam logic [DATA_W-1:0] RD_NONE    = 8'hFF;

  localparam int BIT_SOFTRST = 7;
  localparam int BIT_ENDIAN  = 6;
  localparam int BIT_MAPMODE = 7;

  function automatic logic [15:0] sel_port(int idx);
    case (idx)
      SEL_SPECIAL: sel_port = 16'h0092;
      SEL_EQUIP:   sel_port = 16'h080C;
      SEL_KEYLOCK: sel_port = 16'h0818;
      SEL_SYSCTL:  sel_port = 16'h081C;
      SEL_CACHEST: sel_port = 16'h0823;
      SEL_MAPTYPE: sel_port = 16'h0850;
      SEL_LOCK_A:  sel_port = 16'h0810;
      SEL_LOCK_B:  sel_port = 16'h0812;
      default:     sel_port = 16'hFFFF;
    endcase
  endfunction
endpackage

// File: rtl/sysreg_decode.sv
module sysreg_decode #(
  parameter int AW   = sysreg_pkg::ADDR_W,
  parameter int NHIT = sysreg_pkg::NSEL
) (
  input  logic [AW-1:0]   addr,
  output logic [NHIT-1:0] hit
);
  for (genvar g = 0; g < NHIT; g++) begin : g_cmp
    assign hit[g] = (addr == AW'(sysreg_pkg::sel_port(g)));
  end
endmodule

// File: rtl/sysreg_state.sv
module sysreg_state #(
  parameter int DW = sysreg_pkg::DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_special,
  input  logic          we_sysctl,
  input  logic          we_maptype,
  input  logic          we_lock_a,
  input  logic          we_lock_b,
  input  logic [DW-1:0] wdata,
  output logic [1:0]    lock_q,
  output logic [DW-1:0] ctrl_q,
  output logic          pulse_q,
  output logic          endian_q,
  output logic          map_q
);
  import sysreg_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q   <= 2'b00;
      ctrl_q   <= '0;
      pulse_q  <= 1'b0;
      endian_q <= 1'b0;
      map_q    <= 1'b0;
    end else begin
      pulse_q <= we_special & wdata[BIT_SOFTRST];
      if (we_special && wdata[BIT_ENDIAN]) endian_q <= 1'b1;
      if (we_maptype && wdata[BIT_MAPMODE]) map_q <= 1'b1;
      if (we_lock_a) lock_q[0] <= ~lock_q[0];
      if (we_lock_b) lock_q[1] <= ~lock_q[1];
      if (we_sysctl) ctrl_q <= wdata;
    end
  end
endmodule

// File: rtl/sysreg_bank.sv
module sysreg_bank #(
  parameter int ADDR_W = sysreg_pkg::ADDR_W,
  parameter int DATA_W = sysreg_pkg::DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] port_addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              soft_reset,
  output logic              endian_fault,
  output logic              map_fault,
  output logic [1:0]        nv_lock,
  output logic [DATA_W-1:0] sys_ctrl
);
  import sysreg_pkg::*;

  logic [NSEL-1:0] hit;

  sysreg_decode #(.AW(ADDR_W), .NHIT(NSEL)) u_dec (
    .addr (port_addr),
    .hit  (hit)
  );

  sysreg_state #(.DW(DATA_W)) u_state (
    .clk        (clk),
    .rst        (rst),
    .we_special (wr_en & hit[SEL_SPECIAL]),
    .we_sysctl  (wr_en & hit[SEL_SYSCTL]),
    .we_maptype (wr_en & hit[SEL_MAPTYPE]),
    .we_lock_a  (wr_en & hit[SEL_LOCK_A]),
    .we_lock_b  (wr_en & hit[SEL_LOCK_B]),
    .wdata      (wr_data),
    .lock_q     (nv_lock),
    .ctrl_q     (sys_ctrl),
    .pulse_q    (soft_reset),
    .endian_q   (endian_fault),
    .map_q      (map_fault)
  );

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      if      (hit[SEL_SPECIAL]) rd_data = DATA_W'(RD_SPECIAL);
      else if (hit[SEL_EQUIP])   rd_data = DATA_W'(RD_EQUIP);
      else if (hit[SEL_KEYLOCK]) rd_data = DATA_W'(RD_KEYLOCK);
      else if (hit[SEL_SYSCTL])  rd_data = sys_ctrl;
      else if (hit[SEL_CACHEST]) rd_data = DATA_W'(RD_CACHEST);
      else if (hit[SEL_MAPTYPE]) rd_data = DATA_W'(RD_MAPTYPE);
      else                       rd_data = DATA_W'(RD_NONE);
    end
  end
endmodule

// File: rtl/sysreg_bank_chk.sv
module sysreg_bank_chk (
  input logic        clk,
  input logic        rst,
  input logic [15:0] port_addr,
  input logic        rd_en,
  input logic        wr_en,
  input logic [7:0]  wr_data,
  input logic [7:0]  rd_data,
  input logic        soft_reset,
  input logic        endian_fault,
  input logic        map_fault,
  input logic [1:0]  nv_lock,
  input logic [7:0]  sys_ctrl
);
  // R2: a pulse only ever follows a qualifying write
  a_r2_pulse_cause: assert property (@(posedge clk) disable iff (rst)
    soft_reset |-> $past(wr_en && port_addr == 16'h0092 && wr_data[7]));

  // R3: the endian flag never clears outside reset
  a_r3_endian_sticky: assert property (@(posedge clk) disable iff (rst)
    endian_fault |=> endian_fault);

  // R8: the map flag never clears outside reset
  a_r8_map_sticky: assert property (@(posedge clk) disable iff (rst)
    map_fault |=> map_fault);

  // R5: a lock-port write flips its bit
  a_r5_lock_a_flip: assert property (@(posedge clk) disable iff (rst)
    (wr_en && port_addr == 16'h0810) |=> (nv_lock[0] != $past(nv_lock[0])));

  a_r5_lock_b_flip: assert property (@(posedge clk) disable iff (rst)
    (wr_en && port_addr == 16'h0812) |=> (nv_lock[1] != $past(nv_lock[1])));

  // R6: the control byte takes the written value
  a_r6_ctrl_load: assert property (@(posedge clk) disable iff (rst)
    (wr_en && port_addr == 16'h081C) |=> (sys_ctrl == $past(wr_data)));

  // R10: a write elsewhere leaves the control byte alone
  a_r10_ctrl_hold: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && port_addr == 16'h081C) |=> $stable(sys_ctrl));

  // R9: with no read strobe the read bus sits at zero
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !rd_en |-> (rd_data == 8'h00));

  // R4: the special port reads back its fixed value
  a_r4_special_read: assert property (@(posedge clk) disable iff (rst)
    (rd_en && port_addr == 16'h0092) |-> (rd_data == 8'h40));
endmodule

bind sysreg_bank sysreg_bank_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .port_addr    (port_addr),
  .rd_en        (rd_en),
  .wr_en        (wr_en),
  .wr_data      (wr_data),
  .rd_data      (rd_data),
  .soft_reset   (soft_reset),
  .endian_fault (endian_fault),
  .map_fault    (map_fault),
  .nv_lock      (nv_lock),
  .sys_ctrl     (sys_ctrl)
);

// File: tb/sysreg_bank_test.sv
module sysreg_bank_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] port_addr = '0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic        soft_reset, endian_fault, map_fault;
  logic [1:0]  nv_lock;
  logic [7:0]  sys_ctrl;

  int compared = 0;
  int mismatched = 0;

  // reference state
  int m_lock0 = 0, m_lock1 = 0, m_ctrl = 0, m_pulse = 0, m_end = 0, m_map = 0;

  always #10 clk = ~clk;

  sysreg_bank uut (
    .clk(clk), .rst(rst), .port_addr(port_addr), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .soft_reset(soft_reset),
    .endian_fault(endian_fault), .map_fault(map_fault), .nv_lock(nv_lock),
    .sys_ctrl(sys_ctrl)
  );

  task automatic chk(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int ref_read(int a);
    case (a)
      'h0092: return 'h40;
      'h080C: return 'hFC;
      'h0818: return 'h00;
      'h081C: return m_ctrl;
      'h0823: return 'h03;
      'h0850: return 'h00;
      default: return 'hFF;
    endcase
  endfunction

  task automatic compare_state(string req);
    chk({req, " soft_reset"}, int'(soft_reset), m_pulse);
    chk({req, " endian_fault"}, int'(endian_fault), m_end);
    chk({req, " map_fault"}, int'(map_fault), m_map);
    chk({req, " nv_lock"}, int'(nv_lock), m_lock1 * 2 + m_lock0);
    chk({req, " sys_ctrl"}, int'(sys_ctrl), m_ctrl);
  endtask

  // kind: 0 idle, 1 read, 2 write
  task automatic op(string req, int kind, int a, int d);
    @(negedge clk);
    port_addr = 16'(a);
    wr_data   = 8'(d);
    rd_en     = (kind == 1);
    wr_en     = (kind == 2);
    #1;
    chk({req, " rd_data"}, int'(rd_data), (kind == 1) ? ref_read(a) : 0);
    @(posedge clk);
    m_pulse = 0;
    if (kind == 2) begin
      case (a)
        'h0092: begin
          if (d & 'h80) m_pulse = 1;
          if (d & 'h40) m_end = 1;
        end
        'h0850: if (d & 'h80) m_map = 1;
        'h0810: m_lock0 = 1 - m_lock0;
        'h0812: m_lock1 = 1 - m_lock1;
        'h081C: m_ctrl = d & 'hFF;
        default: ;
      endcase
    end
    #1;
    compare_state(req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; rd_en = 1'b0; wr_en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_lock0 = 0; m_lock1 = 0; m_ctrl = 0; m_pulse = 0; m_end = 0; m_map = 0;
    #1;
    compare_state("R1");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    do_reset();
    // R4 R7 constants
    op("R4", 1, 'h0092, 0);
    op("R7", 1, 'h080C, 0);
    op("R7", 1, 'h0818, 0);
    op("R7", 1, 'h0823, 0);
    op("R7", 1, 'h0850, 0);
    // R9 unmapped and idle
    op("R9", 1, 'h0000, 0);
    op("R9", 1, 'h0093, 0);
    op("R9", 1, 'h0810, 0);
    op("R9", 1, 'h0812, 0);
    op("R9", 1, 'hFFFF, 0);
    op("R9", 0, 'h0092, 0);
    // R5 toggles, data irrelevant
    op("R5", 2, 'h0810, 'h00);
    op("R5", 2, 'h0812, 'hFF);
    op("R5", 2, 'h0810, 'h5A);
    op("R5", 2, 'h0810, 'h01);
    op("R5", 2, 'h0812, 'h00);
    // R6 control byte
    op("R6", 2, 'h081C, 'hA5);
    op("R6", 1, 'h081C, 0);
    op("R6", 2, 'h081C, 'h3C);
    op("R6", 1, 'h081C, 0);
    // R10 ignored writes
    op("R10", 2, 'h0808, 'hFF);
    op("R10", 2, 'h0814, 'hFF);
    op("R10", 2, 'h080C, 'hFF);
    op("R10", 2, 'h0823, 'hFF);
    op("R10", 2, 'h0818, 'hFF);
    op("R10", 2, 'h1234, 'hFF);
    op("R10", 2, 'h0093, 'hFF);
    op("R10", 1, 'h081C, 0);
    // R2 soft reset pulse
    op("R2", 2, 'h0092, 'h3F);
    op("R2", 2, 'h0092, 'h80);
    op("R2", 0, 0, 0);
    op("R2", 2, 'h0092, 'h81);
    op("R2", 2, 'h0092, 'h80);
    op("R2", 0, 0, 0);
    // R3 endian fault
    op("R3", 2, 'h0092, 'h40);
    op("R3", 0, 0, 0);
    op("R3", 2, 'h0092, 'h00);
    op("R3", 2, 'h0092, 'hC0);
    op("R3", 0, 0, 0);
    // R8 map fault
    op("R8", 2, 'h0850, 'h7F);
    op("R8", 2, 'h0850, 'h80);
    op("R8", 2, 'h0850, 'h00);
    op("R8", 1, 'h0850, 0);
    op("R8", 0, 0, 0);
    // R1 second reset clears everything
    do_reset();
    op("R1", 1, 'h081C, 0);
    op("R5", 2, 'h0812, 'h77);
    op("R6", 2, 'h081C, 'hFF);
    op("R6", 1, 'h081C, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule